// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block lives on the host side of an SMBus segment, at the times when the host is addressed as a bus target and a peripheral drives the bus as master to report a change of status. It does not see the pins. A byte-level front end tells it when a START or STOP condition was seen and hands over each received byte. The block answers each byte in the same cycle with an acknowledge decision.

A notification has the shape of a word write: the host's own address with the write bit, then one byte whose upper seven bits name the reporting device, then the status word low byte first, then STOP. The receiver only accepts a frame that holds exactly those four bytes and ends with STOP. It then latches the sender's address and the 16-bit status, raises a one-cycle event strobe and sets an interrupt flag. The flag stays set until software clears it. Only one notification is held at a time. A further complete frame that arrives while one is pending is acknowledged on the bus, then thrown away, and an overflow flag records the loss.

Top module: `hn_notify_rx`

## Requirements
- R1: After reset, `notify`, `irq`, `ovf`, `ack`, `dev_addr` and `status` are all zero.
- R2: In the cycle a byte is presented, `ack` is 1 when the first byte after START equals {`own_addr`, 0}, and for each of the three bytes that follow it.
- R3: The latched `dev_addr` is bits 7:1 of the second byte, and bit 0 of that byte is ignored. `status` is {fourth byte, third byte}.
- R4: A notification is posted only by a STOP that directly follows the fourth byte. `notify` is then 1 for exactly the one cycle after the clock edge that samples the STOP.
- R5: `irq` rises together with `notify` and stays at 1 until `clr` is asserted.
- R6: `clr` held for one cycle clears both `irq` and `ovf` at the next edge.
- R7: A first byte whose upper bits differ from `own_addr`, or whose bit 0 is 1 (read), gets `ack` 0. The rest of that frame gets `ack` 0 and posts nothing.
- R8: A START or STOP that arrives before the frame is complete discards the partial capture. A START restarts the parsing at the address byte.
- R9: A fifth byte in a frame gets `ack` 0, and the following STOP posts nothing.
- R10: While `irq` is 1, a further valid frame is still acknowledged, but it leaves `dev_addr` and `status` unchanged, produces no `notify`, and sets `ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| own_addr | input | 7 | The host's configured 7-bit target address |
| ev_start | input | 1 | START or repeated START seen, one-cycle pulse |
| ev_stop | input | 1 | STOP seen, one-cycle pulse |
| byte_vld | input | 1 | A received byte is presented on `byte_dat` |
| byte_dat | input | 8 | Received byte, MSB first on the wire |
| ack | output | 1 | Acknowledge decision for the byte presented this cycle |
| clr | input | 1 | Software clear of the interrupt and overflow flags |
| notify | output | 1 | One-cycle strobe when a notification is posted |
| irq | output | 1 | Sticky interrupt flag |
| ovf | output | 1 | Sticky flag: a notification was dropped |
| dev_addr | output | 7 | Address of the device that sent the notification |
| status | output | 16 | Status word carried by the notification |

## Verification
The main function is exercised with a clean four-byte frame and a second-byte value whose bit 0 is set, so a swapped or shifted address field shows up. Distinct low and high status bytes catch byte-order errors. Frames cut short by STOP and frames restarted by a repeated START show whether partial data is wrongly posted or whether the restart resumes at the address byte. A frame with a foreign address, a read frame to the host address and an over-long frame separate the address match from the length rule. A second valid frame sent while the first is pending separates dropping with overflow from overwriting.

// File: rtl/hn_pkg.sv
package hn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DEV,
    ST_LO,
    ST_HI,
    ST_END,
    ST_SKIP
  } hn_state_e;
endpackage

// File: rtl/hn_frame.sv
module hn_frame
  import hn_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  output logic              ack,
  output logic              post,
  output logic [ADDR_W-1:0] cap_dev,
  output logic [WORD_W-1:0] cap_word
);

  hn_state_e         state_q, state_d;
  logic [ADDR_W-1:0] dev_q;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              dev_en, lo_en, hi_en;
  logic              addr_hit;

  assign addr_hit = (byte_dat[BYTE_W-1:1] == own_addr) && !byte_dat[0];

  // Next-state logic: START wins over STOP, STOP wins over a byte.
  always_comb begin
    state_d = state_q;
    ack     = 1'b0;
    post    = 1'b0;
    dev_en  = 1'b0;
    lo_en   = 1'b0;
    hi_en   = 1'b0;
    if (ev_start) begin
      state_d = ST_ADDR;
    end else if (ev_stop) begin
      post    = (state_q == ST_END);
      state_d = ST_IDLE;
    end else if (byte_vld) begin
      unique case (state_q)
        ST_ADDR: begin
          if (addr_hit) begin
            ack     = 1'b1;
            state_d = ST_DEV;
          end else begin
            state_d = ST_SKIP;
          end
        end
        ST_DEV: begin
          ack     = 1'b1;
          dev_en  = 1'b1;
          state_d = ST_LO;
        end
        ST_LO: begin
          ack     = 1'b1;
          lo_en   = 1'b1;
          state_d = ST_HI;
        end
        ST_HI: begin
          ack     = 1'b1;
          hi_en   = 1'b1;
          state_d = ST_END;
        end
        ST_END:  state_d = ST_SKIP;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      if (dev_en) dev_q <= byte_dat[BYTE_W-1:1];
      if (lo_en)  lo_q  <= byte_dat;
      if (hi_en)  hi_q  <= byte_dat;
    end
  end

  assign cap_dev  = dev_q;
  assign cap_word = {hi_q, lo_q};

  // R9
  long_frame_no_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_END && byte_vld && !ev_start && !ev_stop) |=> !post);

endmodule

// File: rtl/hn_hold.sv
module hn_hold #(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post,
  input  logic [ADDR_W-1:0] cap_dev,
  input  logic [WORD_W-1:0] cap_word,
  input  logic              clr,
  output logic              notify,
  output logic              irq,
  output logic              ovf,
  output logic [ADDR_W-1:0] dev_o,
  output logic [WORD_W-1:0] word_o
);

  logic              irq_q, irq_d;
  logic              ovf_q, ovf_d;
  logic              notify_q;
  logic              load;
  logic [ADDR_W-1:0] dev_q;
  logic [WORD_W-1:0] word_q;

  // A clear in the same cycle frees the slot for an arriving post.
  always_comb begin
    irq_d = irq_q;
    ovf_d = ovf_q;
    load  = 1'b0;
    if (clr) begin
      irq_d = 1'b0;
      ovf_d = 1'b0;
    end
    if (post) begin
      if (!irq_q || clr) begin
        load  = 1'b1;
        irq_d = 1'b1;
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      ovf_q    <= 1'b0;
      notify_q <= 1'b0;
    end else begin
      irq_q    <= irq_d;
      ovf_q    <= ovf_d;
      notify_q <= load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q  <= '0;
      word_q <= '0;
    end else if (load) begin
      dev_q  <= cap_dev;
      word_q <= cap_word;
    end
  end

  assign notify = notify_q;
  assign irq    = irq_q;
  assign ovf    = ovf_q;
  assign dev_o  = dev_q;
  assign word_o = word_q;

  // R4
  notify_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_q && !clr |=> !notify_q);
  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !clr |=> irq_q);
  // R10
  held_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !clr |=> $stable(dev_q) && $stable(word_q));
  // R10
  ovf_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(irq_q));

endmodule

// File: rtl/hn_notify_rx.sv
module hn_notify_rx #(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  output logic              ack,
  input  logic              clr,
  output logic              notify,
  output logic              irq,
  output logic              ovf,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [WORD_W-1:0] status
);

  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic              post;
  logic [ADDR_W-1:0] cap_dev;
  logic [WORD_W-1:0] cap_word;

  // Assert at once, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  hn_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .own_addr (own_addr),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .byte_vld (byte_vld),
    .byte_dat (byte_dat),
    .ack      (ack),
    .post     (post),
    .cap_dev  (cap_dev),
    .cap_word (cap_word)
  );

  hn_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .post     (post),
    .cap_dev  (cap_dev),
    .cap_word (cap_word),
    .clr      (clr),
    .notify   (notify),
    .irq      (irq),
    .ovf      (ovf),
    .dev_o    (dev_addr),
    .word_o   (status)
  );

  // R4
  notify_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    notify |-> $past(ev_stop));
  // R6
  clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr && !ev_stop |=> !irq && !ovf);

endmodule

// File: tb/tb_hn_notify_rx.sv
module tb_hn_notify_rx;
  localparam int CLK_P = 10;
  localparam logic [6:0] OWN = 7'h08;

  logic        clk;
  logic        rst_n;
  logic [6:0]  own_addr;
  logic        ev_start, ev_stop, byte_vld, clr;
  logic [7:0]  byte_dat;
  logic        ack, notify, irq, ovf;
  logic [6:0]  dev_addr;
  logic [15:0] status;

  int checks = 0;
  int errors = 0;

  hn_notify_rx dut (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .ack(ack),
    .clr(clr), .notify(notify), .irq(irq), .ovf(ovf),
    .dev_addr(dev_addr), .status(status)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic do_start();
    ev_start = 1'b1;
    @(negedge clk);
    ev_start = 1'b0;
  endtask

  task automatic do_stop();
    ev_stop = 1'b1;
    @(negedge clk);
    ev_stop = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    byte_vld = 1'b1;
    byte_dat = b;
    #1;
    chk(ack, exp_ack, tag);
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic do_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(irq, 1'b0, "R6 irq cleared");
    chk(ovf, 1'b0, "R6 ovf cleared");
  endtask

  task automatic frame_body(input logic [7:0] d, input logic [7:0] lo, input logic [7:0] hi);
    do_start();
    send_byte({OWN, 1'b0}, 1'b1, "R2 address ack");
    send_byte(d,  1'b1, "R2 device byte ack");
    send_byte(lo, 1'b1, "R2 low byte ack");
    send_byte(hi, 1'b1, "R2 high byte ack");
  endtask

  task automatic t_reset();
    chk(notify, 0, "R1 notify");
    chk(irq, 0, "R1 irq");
    chk(ovf, 0, "R1 ovf");
    chk(ack, 0, "R1 ack");
    chk(dev_addr, 0, "R1 dev_addr");
    chk(status, 0, "R1 status");
  endtask

  task automatic t_valid();
    frame_body(8'h5B, 8'h34, 8'h12);
    chk(irq, 0, "R4 nothing before STOP");
    do_stop();
    chk(notify, 1, "R4 notify pulse");
    chk(irq, 1, "R5 irq set");
    chk(dev_addr, 7'h2D, "R3 device address upper bits");
    chk(status, 16'h1234, "R3 status byte order");
    @(negedge clk);
    chk(notify, 0, "R4 notify one cycle");
    repeat (3) @(negedge clk);
    chk(irq, 1, "R5 irq sticky");
    do_clr();
  endtask

  task automatic t_foreign();
    do_start();
    send_byte({7'h09, 1'b0}, 1'b0, "R7 foreign address nack");
    send_byte(8'h22, 1'b0, "R7 rest ignored");
    send_byte(8'h33, 1'b0, "R7 rest ignored");
    send_byte(8'h44, 1'b0, "R7 rest ignored");
    do_stop();
    chk(notify, 0, "R7 no notify");
    chk(irq, 0, "R7 no irq");
    do_start();
    send_byte({OWN, 1'b1}, 1'b0, "R7 read nack");
    send_byte(8'h22, 1'b0, "R7 read rest ignored");
    do_stop();
    chk(irq, 0, "R7 read no irq");
  endtask

  task automatic t_early();
    do_start();
    send_byte({OWN, 1'b0}, 1'b1, "R8 address ack");
    send_byte(8'h40, 1'b1, "R8 device ack");
    send_byte(8'h77, 1'b1, "R8 low ack");
    do_stop();
    chk(irq, 0, "R8 early STOP discards");
    chk(notify, 0, "R8 early STOP no notify");
    frame_body(8'h60, 8'h01, 8'h02);
    do_start();
    send_byte({OWN, 1'b0}, 1'b1, "R8 restart at address byte");
    send_byte(8'h62, 1'b1, "R8 device ack");
    send_byte(8'hAA, 1'b1, "R8 low ack");
    send_byte(8'h55, 1'b1, "R8 high ack");
    do_stop();
    chk(notify, 1, "R8 restarted frame posted");
    chk(dev_addr, 7'h31, "R8 dev from restarted frame");
    chk(status, 16'h55AA, "R8 status from restarted frame");
    do_clr();
  endtask

  task automatic t_long();
    frame_body(8'h10, 8'h11, 8'h12);
    send_byte(8'h13, 1'b0, "R9 fifth byte nack");
    do_stop();
    chk(irq, 0, "R9 long frame no irq");
    chk(notify, 0, "R9 long frame no notify");
  endtask

  task automatic t_overflow();
    frame_body(8'h20, 8'hC3, 8'hA5);
    do_stop();
    chk(irq, 1, "R10 first posted");
    frame_body(8'h7E, 8'h00, 8'hFF);
    do_stop();
    chk(notify, 0, "R10 no notify when pending");
    chk(ovf, 1, "R10 ovf set");
    chk(dev_addr, 7'h10, "R10 dev unchanged");
    chk(status, 16'hA5C3, "R10 status unchanged");
    do_clr();
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; own_addr = OWN;
    ev_start = 0; ev_stop = 0; byte_vld = 0; byte_dat = 0; clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_valid();
    t_foreign();
    t_early();
    t_long();
    t_overflow();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule